// File: doc/BRIEF.md
# Byte-Wide Asynchronous SRAM Port with Power-Fail Write Protect

This block is a behavioural model of a byte-wide static memory port. It has three active-low control lines (chip select, output enable and write enable), a 19-bit address, and a data bus. The data bus is split into an input byte, an output byte and an output-drive flag. A single fast sampling clock observes the control levels. From the sampled levels the block decides whether the port is idle, reading or writing. A write is committed to the storage array when its window closes.

A power-fail protect input freezes the port. While it is high, the port ignores every control, address and data input and does not drive the data bus. The storage depth is a parameter, so a simulation can use a small array. Address bits above the configured depth are ignored.

After each write, write enable must stay high for a parameterised number of sample clocks before the port accepts another write. If write enable falls too early, the port ignores that low period and raises a one-clock error pulse.

Top module: `sram_port_wp`

## Requirements
- R1: With wp_i low, ce_ni low, oe_ni low and we_ni high, data_oe_o is 1 and data_o combinationally shows the byte stored at the selected location.
- R2: While ce_ni is high, data_oe_o is 0 whatever oe_ni and we_ni are. data_o reads 0 whenever data_oe_o is 0.
- R3: While we_ni is low, data_oe_o is 0 even when ce_ni and oe_ni are low.
- R4: A write window opens at the first sample clock at which ce_ni and we_ni are both low, whichever of them fell last. Address and data are captured on every sample clock while both stay low.
- R5: The window closes at the first sample clock at which ce_ni or we_ni is high, whichever rose first. The last captured byte is stored at the last captured location and can be read right after that clock.
- R6: After a window closes, no new window opens until we_ni has been sampled high on the closing clock and on REC_CYCLES further sample clocks. A we_ni low sampled on the clock right after that period opens a normal write.
- R7: If we_ni is sampled low on the clock after a high sample while the recovery period is still running, rec_err_o is 1 for exactly the one cycle after that clock. That low period writes nothing.
- R8: While wp_i is high, data_oe_o is 0, rec_err_o stays 0 and nothing is written, whatever the other inputs do.
- R9: If wp_i rises while a write window is open, the window is dropped and its byte is not stored.
- R10: Only the low log2(DEPTH) address bits select a location (DEPTH is a power of two). Addresses that differ only above them reach the same byte.
- R11: After rst_ni is released with the controls high, data_oe_o and rec_err_o are 0 and no write is open.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Fast sampling clock for the control lines |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ce_ni | input | 1 | Chip select, active low |
| oe_ni | input | 1 | Output enable, active low |
| we_ni | input | 1 | Write enable, active low |
| wp_i | input | 1 | Power-fail write protect, active high |
| addr_i | input | ADDR_W (19) | Byte address |
| data_i | input | DATA_W (8) | Write data from the bus |
| data_o | output | DATA_W (8) | Read data toward the bus (0 when not driven) |
| data_oe_o | output | 1 | 1 when the port drives the data bus |
| rec_err_o | output | 1 | One-cycle pulse on a write-enable fall during recovery |

## Verification
The assertions assume that the control, address and data inputs change only away from the rising sample edge. Each level is then seen cleanly on at least one clock. They also assume that address and data stay steady while a write window is open. The bench changes every input on the falling clock edge and holds a write's address and data from the opening of its window until the controls have returned high. The protect input is treated as a level: the bench raises the controls before it releases protection, so that no write opens by surprise.

// File: rtl/sram_port_pkg.sv
package sram_port_pkg;
  typedef enum logic [1:0] {
    CYC_IDLE  = 2'd0,
    CYC_READ  = 2'd1,
    CYC_WRITE = 2'd2,
    CYC_HOLD  = 2'd3
  } cyc_e;
endpackage

// File: rtl/sram_ctrl_decode.sv
module sram_ctrl_decode
  import sram_port_pkg::*;
(
  input  logic ce_ni,
  input  logic oe_ni,
  input  logic we_ni,
  input  logic wp_i,
  output logic ce_act_o,
  output logic we_act_o,
  output logic drive_o
);
  cyc_e cyc;

  // protect masks every control to its inactive level
  assign ce_act_o = ~ce_ni & ~wp_i;
  assign we_act_o = ~we_ni & ~wp_i;

  always_comb begin
    if (!ce_act_o)     cyc = CYC_IDLE;
    else if (we_act_o) cyc = CYC_WRITE;
    else if (!oe_ni)   cyc = CYC_READ;
    else               cyc = CYC_HOLD;
  end

  assign drive_o = (cyc == CYC_READ);
endmodule

// File: rtl/sram_write_ctrl.sv
module sram_write_ctrl #(
  parameter int IDX_W      = 10,
  parameter int DATA_W     = 8,
  parameter int REC_CYCLES = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce_act_i,
  input  logic              we_act_i,
  input  logic              wp_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              commit_o,
  output logic [IDX_W-1:0]  commit_idx_o,
  output logic [DATA_W-1:0] commit_data_o,
  output logic              rec_err_o
);
  localparam int CNT_W = $clog2(REC_CYCLES + 2);
  localparam logic [CNT_W-1:0] REC_LOAD = CNT_W'(REC_CYCLES);

  logic              wr_act_q, we_q, err_q;
  logic [CNT_W-1:0]  rec_cnt_q;
  logic [IDX_W-1:0]  idx_q;
  logic [DATA_W-1:0] data_q;
  logic both, rec_busy, start, close;

  assign both     = ce_act_i & we_act_i;
  assign rec_busy = (rec_cnt_q != '0);
  assign start    = both & ~wr_act_q & ~rec_busy;
  assign close    = wr_act_q & ~both;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_act_q  <= 1'b0;
      we_q      <= 1'b0;
      err_q     <= 1'b0;
      rec_cnt_q <= '0;
      idx_q     <= '0;
      data_q    <= '0;
    end else begin
      we_q  <= we_act_i;
      err_q <= we_act_i & ~we_q & rec_busy;
      if (start || (wr_act_q && both)) begin
        wr_act_q <= 1'b1;
        idx_q    <= idx_i;
        data_q   <= data_i;
      end else if (close) begin
        wr_act_q <= 1'b0;
        // an aborted window starts no recovery
        if (!wp_i) rec_cnt_q <= REC_LOAD;
      end
      if (!close && rec_busy && !we_act_i) rec_cnt_q <= rec_cnt_q - 1'b1;
    end
  end

  assign commit_o      = close & ~wp_i;
  assign commit_idx_o  = idx_q;
  assign commit_data_o = data_q;
  assign rec_err_o     = err_q;

  // R6
  rec_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wr_act_q) |-> $past(rec_cnt_q) == '0);
  // R6
  rec_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_cnt_q <= REC_LOAD);
  // R9
  wp_abort_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wp_i |=> !wr_act_q);
  // R5
  commit_open_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_o |-> wr_act_q);
  // R7
  err_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_err_o |=> !rec_err_o);
endmodule

// File: rtl/sram_byte_array.sv
module sram_byte_array #(
  parameter int DEPTH  = 1024,
  parameter int DATA_W = 8,
  parameter int IDX_W  = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  widx_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [IDX_W-1:0]  ridx_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem[widx_i] <= wdata_i;
  end

  assign rdata_o = mem[ridx_i];
endmodule

// File: rtl/sram_port_wp.sv
module sram_port_wp #(
  parameter int ADDR_W     = 19,
  parameter int DATA_W     = 8,
  parameter int DEPTH      = 1024,
  parameter int REC_CYCLES = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce_ni,
  input  logic              oe_ni,
  input  logic              we_ni,
  input  logic              wp_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] data_o,
  output logic              data_oe_o,
  output logic              rec_err_o
);
  localparam int IDX_W = $clog2(DEPTH);

  logic              ce_act, we_act, drive, commit;
  logic [IDX_W-1:0]  idx, commit_idx;
  logic [DATA_W-1:0] commit_data, rdata;

  assign idx = addr_i[IDX_W-1:0];

  generate
    if (IDX_W < ADDR_W) begin : g_alias
      logic unused_hi;
      assign unused_hi = ^addr_i[ADDR_W-1:IDX_W];
    end
  endgenerate

  sram_ctrl_decode u_decode (
    .ce_ni    (ce_ni),
    .oe_ni    (oe_ni),
    .we_ni    (we_ni),
    .wp_i     (wp_i),
    .ce_act_o (ce_act),
    .we_act_o (we_act),
    .drive_o  (drive)
  );

  sram_write_ctrl #(
    .IDX_W      (IDX_W),
    .DATA_W     (DATA_W),
    .REC_CYCLES (REC_CYCLES)
  ) u_wctrl (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .ce_act_i      (ce_act),
    .we_act_i      (we_act),
    .wp_i          (wp_i),
    .idx_i         (idx),
    .data_i        (data_i),
    .commit_o      (commit),
    .commit_idx_o  (commit_idx),
    .commit_data_o (commit_data),
    .rec_err_o     (rec_err_o)
  );

  sram_byte_array #(
    .DEPTH  (DEPTH),
    .DATA_W (DATA_W),
    .IDX_W  (IDX_W)
  ) u_array (
    .clk_i   (clk_i),
    .we_i    (commit),
    .widx_i  (commit_idx),
    .wdata_i (commit_data),
    .ridx_i  (idx),
    .rdata_o (rdata)
  );

  assign data_oe_o = drive;
  assign data_o    = drive ? rdata : '0;

  // R8
  wp_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wp_i |-> !data_oe_o && !commit);
  // R2
  idle_hiz_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ce_ni |-> !data_oe_o && data_o == '0);
  // R3
  we_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_ni |-> !data_oe_o);
endmodule

// File: tb/sram_port_wp_bench.sv
module sram_port_wp_bench;
  localparam int ADDR_W = 19;
  localparam int DATA_W = 8;
  localparam int DEPTH  = 64;
  localparam int REC    = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, wp = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [DATA_W-1:0] din = '0;
  logic [DATA_W-1:0] dout;
  logic doe, rerr;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;
  logic [DATA_W-1:0] exp_mem [DEPTH];

  always #10 clk = ~clk;

  sram_port_wp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH), .REC_CYCLES(REC))
  u_sram_port_wp (
    .clk_i(clk), .rst_ni(rst_n), .ce_ni(ce_n), .oe_ni(oe_n), .we_ni(we_n),
    .wp_i(wp), .addr_i(addr), .data_i(din), .data_o(dout),
    .data_oe_o(doe), .rec_err_o(rerr)
  );

  function automatic logic [DATA_W-1:0] exp_rd(logic [ADDR_W-1:0] a);
    return exp_mem[a[$clog2(DEPTH)-1:0]];
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // mode 0: fall together, WE ends; 1: CE falls last, CE ends; 2: WE falls last, WE ends
  task automatic wr(logic [ADDR_W-1:0] a, logic [DATA_W-1:0] d, int mode);
    @(negedge clk);
    addr = a; din = d; oe_n = 1'b1;
    if (mode == 1) begin we_n = 1'b0; @(negedge clk); ce_n = 1'b0; end
    else if (mode == 2) begin ce_n = 1'b0; @(negedge clk); we_n = 1'b0; end
    else begin ce_n = 1'b0; we_n = 1'b0; end
    repeat (2) @(negedge clk);
    if (mode == 1) begin ce_n = 1'b1; @(negedge clk); we_n = 1'b1; end
    else begin we_n = 1'b1; @(negedge clk); ce_n = 1'b1; end
    repeat (REC + 1) @(negedge clk);
    exp_mem[a[$clog2(DEPTH)-1:0]] = d;
  endtask

  task automatic rd(logic [ADDR_W-1:0] a, string req);
    @(negedge clk);
    addr = a; ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
    #5;
    check({req, " drive"}, 32'(doe), 32'd1);
    check({req, " data"}, 32'(dout), 32'(exp_rd(a)));
    @(negedge clk);
    ce_n = 1'b1; oe_n = 1'b1;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : main
    logic [ADDR_W-1:0] a;
    logic [DATA_W-1:0] old_v;
    int unsigned seed_v;
    seed_v = $urandom(32'h5eed);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #5;
    // R11
    check("R11 drive", 32'(doe), 32'd0);
    check("R11 err", 32'(rerr), 32'd0);

    for (int i = 0; i < DEPTH; i++) wr(ADDR_W'(i), DATA_W'(i * 7 + 3), i % 3);

    // R1 R5 each ordering
    for (int i = 0; i < 3; i++) begin
      a = ADDR_W'(10 + i);
      wr(a, DATA_W'(8'hA0 + i), i);
      rd(a, "R5");
    end
    rd(ADDR_W'(5), "R1");

    // R2 CE high with other combos
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      ce_n = 1'b1; oe_n = i[0]; we_n = i[1]; addr = ADDR_W'(7);
      #5;
      check("R2 drive", 32'(doe), 32'd0);
      check("R2 data", 32'(dout), 32'd0);
    end
    @(negedge clk); oe_n = 1'b1; we_n = 1'b1;
    repeat (REC + 1) @(negedge clk);

    // R3 WE low with CE and OE low: drivers off; write keeps same byte
    @(negedge clk);
    addr = ADDR_W'(20); din = exp_rd(ADDR_W'(20)); ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b0;
    #5;
    check("R3 drive", 32'(doe), 32'd0);
    @(negedge clk); we_n = 1'b1; oe_n = 1'b1;
    @(negedge clk); ce_n = 1'b1;
    repeat (REC + 1) @(negedge clk);

    // R4 data captured last while both low is committed
    @(negedge clk);
    addr = ADDR_W'(21); din = 8'h11; ce_n = 1'b0; we_n = 1'b0;
    @(negedge clk); din = 8'h22;
    @(negedge clk); we_n = 1'b1;
    @(negedge clk); ce_n = 1'b1;
    exp_mem[21] = 8'h22;
    repeat (REC + 1) @(negedge clk);
    rd(ADDR_W'(21), "R4");

    // R7 early fall at the last recovery clock
    @(negedge clk);
    addr = ADDR_W'(30); din = 8'h5A; ce_n = 1'b0; we_n = 1'b0;
    repeat (2) @(negedge clk);
    we_n = 1'b1;
    repeat (REC) @(negedge clk);
    we_n = 1'b0; din = 8'hC3;
    @(negedge clk); #5;
    check("R7 pulse", 32'(rerr), 32'd1);
    @(negedge clk); #5;
    check("R7 single", 32'(rerr), 32'd0);
    @(negedge clk); we_n = 1'b1; ce_n = 1'b1;
    exp_mem[30] = 8'h5A;
    repeat (REC + 1) @(negedge clk);
    rd(ADDR_W'(30), "R7 ignored");

    // R6 fall right after recovery opens a normal write
    @(negedge clk);
    addr = ADDR_W'(31); din = 8'h3C; ce_n = 1'b0; we_n = 1'b0;
    repeat (2) @(negedge clk);
    we_n = 1'b1;
    repeat (REC + 1) @(negedge clk);
    we_n = 1'b0; din = 8'h96;
    @(negedge clk); #5;
    check("R6 no err", 32'(rerr), 32'd0);
    @(negedge clk); we_n = 1'b1;
    @(negedge clk); ce_n = 1'b1;
    exp_mem[31] = 8'h96;
    repeat (REC + 1) @(negedge clk);
    rd(ADDR_W'(31), "R6");

    // R8 protect
    old_v = exp_rd(ADDR_W'(40));
    @(negedge clk);
    wp = 1'b1; addr = ADDR_W'(40); din = ~old_v; ce_n = 1'b0; we_n = 1'b1;
    @(negedge clk); we_n = 1'b0;
    @(negedge clk); #5;
    check("R8 err", 32'(rerr), 32'd0);
    @(negedge clk); we_n = 1'b1; oe_n = 1'b0;
    #5;
    check("R8 drive", 32'(doe), 32'd0);
    @(negedge clk); ce_n = 1'b1; oe_n = 1'b1;
    @(negedge clk); wp = 1'b0;
    repeat (REC + 1) @(negedge clk);
    rd(ADDR_W'(40), "R8 unchanged");

    // R9 protect during an open window
    old_v = exp_rd(ADDR_W'(41));
    @(negedge clk);
    addr = ADDR_W'(41); din = ~old_v; ce_n = 1'b0; we_n = 1'b0;
    repeat (2) @(negedge clk);
    wp = 1'b1;
    @(negedge clk); ce_n = 1'b1; we_n = 1'b1;
    @(negedge clk); wp = 1'b0;
    repeat (REC + 1) @(negedge clk);
    rd(ADDR_W'(41), "R9");

    // R10 aliasing via high address bits
    wr({13'h1ABC, 6'd50}, 8'hE7, 0);
    rd({13'h0001, 6'd50}, "R10");

    // random mix
    for (int i = 0; i < 150; i++) begin
      a = ADDR_W'($urandom);
      if ($urandom % 2 == 0) wr(a, DATA_W'($urandom), int'($urandom % 3));
      else rd(a, "R1 random");
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule